// File: doc/BRIEF.md
# TFT Panel Power-Up Command Sequencer

This block brings a small 16-bit colour TFT panel controller out of reset by playing a fixed list of command bytes, each followed by the parameter bytes that command needs. After reset it stays silent until a one-cycle start pulse arrives. It then presents the list one byte at a time on a byte-wide stream. A flag on the stream marks each byte as a command or as a parameter. A byte moves on only when the downstream serializer accepts it through a valid/ready handshake.

Two fixed waits are built into the list. The first follows the software reset command and the second follows the sleep-exit command. Their lengths are set in milliseconds and converted to clock cycles by a parameter. When the memory-write command has been accepted, the block raises a done flag and holds it until the next start. A start pulse that arrives while the list is still running has no effect. The addressing window commands take the panel's column and row limits from parameters; both default to 128.

Top module: `panel_init_seq`

## Requirements
- R1: After reset, and until the first start pulse, out_valid and seq_done are both 0 whatever out_ready does.
- R2: A start pulse while idle makes out_valid high on the next cycle, presenting command byte 0x01 with out_is_data=0.
- R3: The accepted bytes form this 37-byte list, where C marks out_is_data=0 and P marks out_is_data=1: C01, C11, C3A P05, C26 P02, C13, CB6 PFF P06, CB1 P08 P02, CB4 P07, CC0 P0A P02, CC1 P02, CC5 P50 P63, CC7 P00, C2A P00 P00 P(col hi) P(col lo), C2B P00 P00 P(row hi) P(row lo), C29, C2C.
- R4: While out_valid is 1 and out_ready is 0, out_byte and out_is_data stay unchanged and the list does not advance.
- R5: After byte 0x01 is accepted, out_valid stays low for exactly LONG_MS*CYC_PER_MS cycles, then rises with the next byte.
- R6: After command 0x11 is accepted, out_valid stays low for exactly SHORT_MS*CYC_PER_MS cycles, then rises with the next byte.
- R7: After any other accepted byte except the last, out_valid is high on the very next cycle. With out_ready held high, the run from start to done takes 37 + LONG_N + SHORT_N + 1 cycles.
- R8: seq_done rises on the cycle after command 0x2C is accepted and stays high, with out_valid low, until a start pulse.
- R9: A start pulse while bytes are being sent or during a wait is ignored: the list continues exactly as if no pulse had arrived.
- R10: A start pulse while seq_done is high clears seq_done on the next cycle and replays the whole list from 0x01.
- R11: The column window ends at PANEL_W and the row window at PANEL_H, each sent high byte first (byte positions 28/29 and 33/34 of the list, counting from 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins the sequence |
| out_ready | input | 1 | Downstream accepts the presented byte |
| out_valid | output | 1 | A byte is presented |
| out_byte | output | 8 | Presented command or parameter byte |
| out_is_data | output | 1 | 0 for a command byte, 1 for a parameter byte |
| seq_done | output | 1 | Whole list has been accepted |

## Verification
The bench targets the exact length of both waits. A timer that is off by one would bring out_valid back a cycle early or late. It also checks that the two waits are never swapped, which would show up as a short gap after the reset command. Back-pressure is applied at random. A design that advanced on valid alone would skip parameter bytes, and one that changed out_byte during a stall would hand the serializer a different byte from the one it latched. Start pulses are injected both in the middle of a run and after completion, which catches a design that restarts while busy or that cannot be re-armed from done. The row limit is set different from the column limit, so mixing up the two window commands shows in the accepted stream.

// File: rtl/panel_init_pkg.sv
package panel_init_pkg;

   localparam int BYTE_W     = 8;
   localparam int STEP_COUNT = 37;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [1:0] {
      PAUSE_NONE  = 2'd0,
      PAUSE_LONG  = 2'd1,
      PAUSE_SHORT = 2'd2
   } pause_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SEND  = 2'd1,
      ST_PAUSE = 2'd2,
      ST_DONE  = 2'd3
   } seq_state_e;

   typedef struct packed {
      logic   is_param;
      byte_t  value;
      pause_e pause;
      logic   last;
   } step_t;

   localparam byte_t OP_SOFT_RESET = 8'h01;
   localparam byte_t OP_WAKE       = 8'h11;
   localparam byte_t OP_RAM_WRITE  = 8'h2C;

   function automatic step_t op(byte_t v, pause_e p, logic l);
      step_t s;
      s.is_param = 1'b0;
      s.value    = v;
      s.pause    = p;
      s.last     = l;
      return s;
   endfunction

   function automatic step_t arg(byte_t v);
      step_t s;
      s.is_param = 1'b1;
      s.value    = v;
      s.pause    = PAUSE_NONE;
      s.last     = 1'b0;
      return s;
   endfunction

   // Fixed power-up list; order is behaviour.
   function automatic step_t step_at(int unsigned idx, logic [15:0] col_end,
                                     logic [15:0] row_end);
      step_t s;
      case (idx)
         0:  s = op(OP_SOFT_RESET, PAUSE_LONG, 1'b0);
         1:  s = op(OP_WAKE, PAUSE_SHORT, 1'b0);
         2:  s = op(8'h3A, PAUSE_NONE, 1'b0);
         3:  s = arg(8'h05);
         4:  s = op(8'h26, PAUSE_NONE, 1'b0);
         5:  s = arg(8'h02);
         6:  s = op(8'h13, PAUSE_NONE, 1'b0);
         7:  s = op(8'hB6, PAUSE_NONE, 1'b0);
         8:  s = arg(8'hFF);
         9:  s = arg(8'h06);
         10: s = op(8'hB1, PAUSE_NONE, 1'b0);
         11: s = arg(8'h08);
         12: s = arg(8'h02);
         13: s = op(8'hB4, PAUSE_NONE, 1'b0);
         14: s = arg(8'h07);
         15: s = op(8'hC0, PAUSE_NONE, 1'b0);
         16: s = arg(8'h0A);
         17: s = arg(8'h02);
         18: s = op(8'hC1, PAUSE_NONE, 1'b0);
         19: s = arg(8'h02);
         20: s = op(8'hC5, PAUSE_NONE, 1'b0);
         21: s = arg(8'h50);
         22: s = arg(8'h63);
         23: s = op(8'hC7, PAUSE_NONE, 1'b0);
         24: s = arg(8'h00);
         25: s = op(8'h2A, PAUSE_NONE, 1'b0);
         26: s = arg(8'h00);
         27: s = arg(8'h00);
         28: s = arg(col_end[15:8]);
         29: s = arg(col_end[7:0]);
         30: s = op(8'h2B, PAUSE_NONE, 1'b0);
         31: s = arg(8'h00);
         32: s = arg(8'h00);
         33: s = arg(row_end[15:8]);
         34: s = arg(row_end[7:0]);
         35: s = op(8'h29, PAUSE_NONE, 1'b0);
         36: s = op(OP_RAM_WRITE, PAUSE_NONE, 1'b1);
         default: s = op(8'h00, PAUSE_NONE, 1'b1);
      endcase
      return s;
   endfunction

endpackage

// File: rtl/pis_step_rom.sv
module pis_step_rom
   import panel_init_pkg::*;
#(
   parameter int IDX_W       = 6,
   parameter int PANEL_W     = 128,
   parameter int PANEL_H     = 128,
   parameter bit TABLE_STYLE = 1'b0
) (
   input  logic [IDX_W-1:0] idx,
   output step_t            step
);

   localparam logic [15:0] COL_END = 16'(PANEL_W);
   localparam logic [15:0] ROW_END = 16'(PANEL_H);

   generate
      if (TABLE_STYLE) begin : g_table
         step_t table_q [STEP_COUNT];
         for (genvar g = 0; g < STEP_COUNT; g++) begin : g_row
            assign table_q[g] = step_at(g, COL_END, ROW_END);
         end
         always_comb begin
            if (idx < IDX_W'(STEP_COUNT)) step = table_q[idx];
            else                           step = step_at(STEP_COUNT, COL_END, ROW_END);
         end
      end else begin : g_mux
         always_comb step = step_at(int'(idx), COL_END, ROW_END);
      end
   endgenerate

endmodule

// File: rtl/pis_pause_timer.sv
module pis_pause_timer
   import panel_init_pkg::*;
#(
   parameter int CYC_PER_MS = 250000,
   parameter int LONG_MS    = 500,
   parameter int SHORT_MS   = 5
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   load,
   input  pause_e sel,
   output logic   zero
);

   localparam int LONG_N  = LONG_MS * CYC_PER_MS;
   localparam int SHORT_N = SHORT_MS * CYC_PER_MS;
   localparam int MAX_N   = (LONG_N > SHORT_N) ? LONG_N : SHORT_N;
   localparam int CNT_W   = $clog2(MAX_N + 1) + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload;

   always_comb begin
      case (sel)
         PAUSE_LONG:  reload = CNT_W'(LONG_N - 1);
         PAUSE_SHORT: reload = CNT_W'(SHORT_N - 1);
         default:     reload = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= reload;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/pis_ctrl.sv
module pis_ctrl
   import panel_init_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             ready,
   input  step_t            step,
   input  logic             tmr_zero,
   output logic [IDX_W-1:0] idx,
   output seq_state_e       state,
   output logic             tmr_load,
   output pause_e           tmr_sel
);

   logic accept;
   assign accept = (state == ST_SEND) && ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
      end else begin
         case (state)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  state <= ST_SEND;
                  idx   <= '0;
               end
            end
            ST_SEND: begin
               if (ready) begin
                  if (step.last) begin
                     state <= ST_DONE;
                  end else begin
                     idx <= idx + 1'b1;
                     if (step.pause != PAUSE_NONE) state <= ST_PAUSE;
                  end
               end
            end
            ST_PAUSE: begin
               if (tmr_zero) state <= ST_SEND;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign tmr_load = accept && !step.last && (step.pause != PAUSE_NONE);
   assign tmr_sel  = step.pause;

endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
   import panel_init_pkg::*;
#(
   parameter int CYC_PER_MS  = 250000,
   parameter int LONG_MS     = 500,
   parameter int SHORT_MS    = 5,
   parameter int PANEL_W     = 128,
   parameter int PANEL_H     = 128,
   parameter bit TABLE_STYLE = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       out_ready,
   output logic       out_valid,
   output logic [7:0] out_byte,
   output logic       out_is_data,
   output logic       seq_done
);

   localparam int IDX_W = $clog2(STEP_COUNT);

   generate
      if (CYC_PER_MS < 1)  begin : g_bad_rate   $error("CYC_PER_MS must be at least 1"); end
      if (LONG_MS < 1)     begin : g_bad_long   $error("LONG_MS must be at least 1"); end
      if (SHORT_MS < 1)    begin : g_bad_short  $error("SHORT_MS must be at least 1"); end
      if (longint'(LONG_MS) * longint'(CYC_PER_MS) > 64'd2147483647)
                           begin : g_bad_span   $error("long wait exceeds 31-bit count"); end
      if (PANEL_W < 1 || PANEL_W > 65535) begin : g_bad_w $error("PANEL_W out of range"); end
      if (PANEL_H < 1 || PANEL_H > 65535) begin : g_bad_h $error("PANEL_H out of range"); end
   endgenerate

   step_t            cur_step;
   logic [IDX_W-1:0] ctl_idx;
   seq_state_e       ctl_state;
   logic             tmr_load;
   pause_e           tmr_sel;
   logic             tmr_zero;

   pis_step_rom #(
      .IDX_W(IDX_W), .PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .TABLE_STYLE(TABLE_STYLE)
   ) u_rom (
      .idx (ctl_idx),
      .step(cur_step)
   );

   pis_pause_timer #(
      .CYC_PER_MS(CYC_PER_MS), .LONG_MS(LONG_MS), .SHORT_MS(SHORT_MS)
   ) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .load (tmr_load),
      .sel  (tmr_sel),
      .zero (tmr_zero)
   );

   pis_ctrl #(.IDX_W(IDX_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .ready   (out_ready),
      .step    (cur_step),
      .tmr_zero(tmr_zero),
      .idx     (ctl_idx),
      .state   (ctl_state),
      .tmr_load(tmr_load),
      .tmr_sel (tmr_sel)
   );

   assign out_valid   = (ctl_state == ST_SEND);
   assign out_byte    = cur_step.value;
   assign out_is_data = cur_step.is_param;
   assign seq_done    = (ctl_state == ST_DONE);

endmodule

// File: rtl/pis_checker.sv
module pis_checker
   import panel_init_pkg::*;
#(
   parameter int CYC_PER_MS = 250000,
   parameter int LONG_MS    = 500,
   parameter int SHORT_MS   = 5,
   parameter int IDX_W      = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             out_ready,
   input logic             out_valid,
   input logic [7:0]       out_byte,
   input logic             out_is_data,
   input logic             seq_done,
   input seq_state_e       ctl_state,
   input logic [IDX_W-1:0] ctl_idx,
   input logic             tmr_zero
);

   localparam int LONG_N  = LONG_MS * CYC_PER_MS;
   localparam int SHORT_N = SHORT_MS * CYC_PER_MS;

   logic        took;
   logic        gap_on;
   int unsigned gap_len;
   int unsigned gap_exp;

   assign took = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_on  <= 1'b0;
         gap_len <= 0;
         gap_exp <= 0;
      end else if (took && !out_is_data &&
                   (out_byte == OP_SOFT_RESET || out_byte == OP_WAKE)) begin
         gap_on  <= 1'b1;
         gap_len <= 0;
         gap_exp <= (out_byte == OP_SOFT_RESET) ? LONG_N : SHORT_N;
      end else if (gap_on && out_valid) begin
         gap_on <= 1'b0;
      end else if (gap_on) begin
         gap_len <= gap_len + 1;
      end
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_state == ST_IDLE && !start) |=> (ctl_state == ST_IDLE && !out_valid && !seq_done));

   assert_first_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_state == ST_IDLE && start) |=> (out_valid && out_byte == OP_SOFT_RESET && !out_is_data));

   assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_is_data)));

   assert_gap_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_on && out_valid) |-> (gap_len == gap_exp));

   assert_reset_cmd_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (took && !out_is_data && out_byte == OP_SOFT_RESET) |=> !out_valid);

   assert_wake_cmd_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (took && !out_is_data && out_byte == OP_WAKE) |=> !out_valid);

   assert_no_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (took && (out_is_data || (out_byte != OP_SOFT_RESET && out_byte != OP_WAKE &&
                                out_byte != OP_RAM_WRITE))) |=> out_valid);

   assert_done_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (took && !out_is_data && out_byte == OP_RAM_WRITE) |=> (seq_done && !out_valid));

   assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && !start) |=> seq_done);

   assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_state == ST_PAUSE && start && !tmr_zero) |=> (ctl_state == ST_PAUSE && $stable(ctl_idx)));

   assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && start) |=> (!seq_done && out_valid && out_byte == OP_SOFT_RESET));

endmodule

bind panel_init_seq pis_checker #(
   .CYC_PER_MS(CYC_PER_MS), .LONG_MS(LONG_MS), .SHORT_MS(SHORT_MS), .IDX_W(IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .out_ready  (out_ready),
   .out_valid  (out_valid),
   .out_byte   (out_byte),
   .out_is_data(out_is_data),
   .seq_done   (seq_done),
   .ctl_state  (ctl_state),
   .ctl_idx    (ctl_idx),
   .tmr_zero   (tmr_zero)
);

// File: tb/tb_panel_init_seq.sv
`timescale 1ns/1ps
module tb_panel_init_seq;

   localparam int CYC_PER_MS = 2;
   localparam int LONG_MS    = 500;
   localparam int SHORT_MS   = 5;
   localparam int PANEL_W    = 128;
   localparam int PANEL_H    = 160;
   localparam int LONG_N     = LONG_MS * CYC_PER_MS;
   localparam int SHORT_N    = SHORT_MS * CYC_PER_MS;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       out_ready = 1'b0;
   logic       out_valid;
   logic [7:0] out_byte;
   logic       out_is_data;
   logic       seq_done;

   always #2 clk = ~clk;

   panel_init_seq #(
      .CYC_PER_MS(CYC_PER_MS), .LONG_MS(LONG_MS), .SHORT_MS(SHORT_MS),
      .PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .TABLE_STYLE(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .out_ready(out_ready),
      .out_valid(out_valid), .out_byte(out_byte), .out_is_data(out_is_data),
      .seq_done(seq_done)
   );

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   ended   = 1'b0;
   int   cyc     = 0;

   // Expected list
   logic [7:0] exp_b[$];
   bit         exp_d[$];
   int         exp_p[$];

   task automatic add_cmd(input logic [7:0] b, input int pause_cycles);
      exp_b.push_back(b); exp_d.push_back(1'b0); exp_p.push_back(pause_cycles);
   endtask
   task automatic add_par(input logic [7:0] b);
      exp_b.push_back(b); exp_d.push_back(1'b1); exp_p.push_back(0);
   endtask

   task automatic check(input bit ok, input string tag, input string act, input string expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %s expected %s", tag, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // Behavioural reference: 0 idle, 1 sending, 2 waiting, 3 done
   int m_st = 0, m_idx = 0, m_cnt = 0;
   bit m_stall = 0, m_r9 = 0, m_r10 = 0;
   bit checking = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_idx = 0; m_cnt = 0; m_stall = 0; m_r9 = 0; m_r10 = 0;
      end else begin
         m_stall = (m_st == 1) && !out_ready;
         m_r9    = start && (m_st == 1 || m_st == 2);
         m_r10   = start && (m_st == 3);
         case (m_st)
            0, 3: if (start) begin m_st = 1; m_idx = 0; end
            1: if (out_ready) begin
                  if (m_idx == exp_b.size() - 1) m_st = 3;
                  else begin
                     if (exp_p[m_idx] > 0) begin m_cnt = exp_p[m_idx]; m_st = 2; end
                     m_idx++;
                  end
               end
            2: if (m_cnt == 1) m_st = 1; else m_cnt--;
            default: m_st = 0;
         endcase
      end
   end

   always @(negedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !ended) begin
         check(1'b0, "watchdog", "still running", "finished");
         finish_run();
      end
      if (rst_n && checking) begin
         bit    e_valid, e_done, ok;
         string tag;
         e_valid = (m_st == 1);
         e_done  = (m_st == 3);
         ok = (out_valid === e_valid) && (seq_done === e_done);
         if (e_valid) ok = ok && (out_byte === exp_b[m_idx]) && (out_is_data === exp_d[m_idx]);
         if (m_r9)                              tag = "R9";
         else if (m_r10)                        tag = "R10";
         else if (m_st == 0)                    tag = "R1";
         else if (m_st == 3)                    tag = "R8";
         else if (m_st == 2)                    tag = (m_idx == 1) ? "R5" : "R6";
         else if (m_stall)                      tag = "R4";
         else if (m_idx == 0)                   tag = "R2";
         else if (m_idx >= 25 && m_idx <= 34)   tag = "R11";
         else                                   tag = "R3";
         check(ok, tag,
               $sformatf("v=%0b done=%0b dc=%0b b=%02h", out_valid, seq_done, out_is_data, out_byte),
               $sformatf("v=%0b done=%0b dc=%0b b=%02h", e_valid, e_done,
                         e_valid ? exp_d[m_idx] : 1'b0, e_valid ? exp_b[m_idx] : 8'h00));
      end
   end

   initial begin
      logic [7:0] cap[$];
      int n;
      add_cmd(8'h01, LONG_N);  add_cmd(8'h11, SHORT_N);
      add_cmd(8'h3A, 0); add_par(8'h05);
      add_cmd(8'h26, 0); add_par(8'h02);
      add_cmd(8'h13, 0);
      add_cmd(8'hB6, 0); add_par(8'hFF); add_par(8'h06);
      add_cmd(8'hB1, 0); add_par(8'h08); add_par(8'h02);
      add_cmd(8'hB4, 0); add_par(8'h07);
      add_cmd(8'hC0, 0); add_par(8'h0A); add_par(8'h02);
      add_cmd(8'hC1, 0); add_par(8'h02);
      add_cmd(8'hC5, 0); add_par(8'h50); add_par(8'h63);
      add_cmd(8'hC7, 0); add_par(8'h00);
      add_cmd(8'h2A, 0); add_par(8'h00); add_par(8'h00);
      add_par(8'(PANEL_W >> 8)); add_par(8'(PANEL_W & 255));
      add_cmd(8'h2B, 0); add_par(8'h00); add_par(8'h00);
      add_par(8'(PANEL_H >> 8)); add_par(8'(PANEL_H & 255));
      add_cmd(8'h29, 0); add_cmd(8'h2C, 0);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      checking = 1'b1;

      // R1: idle with toggling ready, no start
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         out_ready = i[0];
      end
      check(!out_valid && !seq_done, "R1",
            $sformatf("v=%0b done=%0b", out_valid, seq_done), "v=0 done=0");

      // Phase 1: ready held high, measure run length and capture stream
      out_ready = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      check(out_valid && out_byte == 8'h01 && !out_is_data, "R2",
            $sformatf("v=%0b b=%02h dc=%0b", out_valid, out_byte, out_is_data), "v=1 b=01 dc=0");
      if (out_valid) cap.push_back(out_byte);
      while (!seq_done && n < 5000) begin
         @(negedge clk);
         n++;
         if (out_valid) cap.push_back(out_byte);
      end
      check(n == 37 + LONG_N + SHORT_N + 1, "R7", $sformatf("%0d cycles", n),
            $sformatf("%0d cycles", 37 + LONG_N + SHORT_N + 1));
      check(cap.size() == 37, "R3", $sformatf("%0d bytes", cap.size()), "37 bytes");
      if (cap.size() == 37) begin
         check(cap[28] == 8'h00 && cap[29] == 8'h80, "R11",
               $sformatf("%02h %02h", cap[28], cap[29]), "00 80");
         check(cap[33] == 8'h00 && cap[34] == 8'hA0, "R11",
               $sformatf("%02h %02h", cap[33], cap[34]), "00 A0");
         check(cap[36] == 8'h2C && cap[0] == 8'h01, "R3",
               $sformatf("%02h..%02h", cap[0], cap[36]), "01..2C");
      end

      // Hold in done
      repeat (15) @(negedge clk);
      check(seq_done && !out_valid, "R8",
            $sformatf("done=%0b v=%0b", seq_done, out_valid), "done=1 v=0");

      // Phase 2: restart under random back-pressure with busy start pulses
      start = 1'b1;
      out_ready = 1'b0;
      @(negedge clk);
      start = 1'b0;
      check(!seq_done && out_valid && out_byte == 8'h01, "R10",
            $sformatf("done=%0b v=%0b b=%02h", seq_done, out_valid, out_byte), "done=0 v=1 b=01");
      n = 0;
      while (!seq_done && n < 20000) begin
         out_ready = ($urandom_range(0, 3) != 0);
         start     = (n % 53 == 7);
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      check(seq_done, "R9", $sformatf("done=%0b", seq_done), "done=1");

      // Done must survive ready noise
      for (int i = 0; i < 25; i++) begin
         out_ready = ($urandom_range(0, 1) != 0);
         @(negedge clk);
      end
      check(seq_done && !out_valid, "R8",
            $sformatf("done=%0b v=%0b", seq_done, out_valid), "done=1 v=0");

      // Phase 3: replay from done with ready high
      out_ready = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!seq_done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      check(seq_done && n == 37 + LONG_N + SHORT_N, "R10",
            $sformatf("done=%0b after %0d", seq_done, n),
            $sformatf("done=1 after %0d", 37 + LONG_N + SHORT_N));

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule